// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block gathers level-sensitive interrupt sources into byte-wide groups and raises one combined request per group toward a parent interrupt controller. A bank holds four groups of eight sources, so one bank spans a 32-bit register word. Every source has an enable bit, and a group's request is high while any of its enabled sources is active.

Software changes the enables only through two write-one registers: one sets bits and the other clears them, so no read-modify-write sequence is needed. A status register returns each source's level masked by its enable. The register bus is a single-cycle interface with a write strobe, a read strobe and a word offset. Read data is combinational from the current state.

Top module: `irq_combiner`

## Requirements
- R1: After reset all enable bits are 0, every group output is 0, and status reads as 0 whatever the source levels are.
- R2: A write to offset 0x0 sets each enable bit whose written data bit is 1 and leaves the other enable bits unchanged. The new value takes effect on the next clock edge.
- R3: A write to offset 0x4 clears each enable bit whose written data bit is 1 and leaves the other enable bits unchanged.
- R4: A read at offset 0xC returns source levels ANDed with the enable bits, with source i on data bit i.
- R5: Group g (g = 0..NGRP-1) covers sources 8*g through 8*g+7 (byte lane g). Its output equals the OR of those enabled, active sources, registered once. The output follows the inputs one clock edge after the inputs or the enables change.
- R6: A read at offset 0x0 returns the enable bits. A read at offset 0x4 returns 0.
- R7: A write to any other offset (0x8, 0xC, or any offset above 0xC) leaves the enables unchanged. A read from any offset other than 0x0 and 0xC returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NSRC | Level interrupt sources |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW | Byte offset |
| wdata | input | NSRC | Write data |
| rdata | output | NSRC | Read data, 0 when rd_en is low |
| grp_irq | output | NGRP | Combined request per group |

## Verification
The bench uses the default build: four groups, 32 sources and an 8-bit offset. With this build every byte lane has its own output, so the bench can detect an error that sends one lane to the wrong output. The 8-bit offset also lets the bench write to the unused offset 0x8, to offsets above 0xC, and to the read-only status offset. Random writes to the set and clear registers, mixed with random source levels, are compared each cycle with a reference enable word and group OR kept in the bench.

// File: rtl/irq_combiner.sv
module irq_combiner #(
  parameter int NGRP = 4,
  parameter int AW   = 8,
  localparam int NSRC = NGRP * 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] rdata,
  output logic [NGRP-1:0] grp_irq
);
  localparam logic [AW-1:0] OFS_SET = AW'(8'h00);
  localparam logic [AW-1:0] OFS_CLR = AW'(8'h04);
  localparam logic [AW-1:0] OFS_STS = AW'(8'h0C);

  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] masked;
  logic [NGRP-1:0] grp_d;

  assign masked = src_i & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      en_q <= '0;
    else if (wr_en && addr == OFS_SET)
      en_q <= en_q | wdata;
    else if (wr_en && addr == OFS_CLR)
      en_q <= en_q & ~wdata;
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_d[g] = |masked[8*g +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grp_irq <= '0;
    else        grp_irq <= grp_d;
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr == OFS_SET)      rdata = en_q;
      else if (addr == OFS_STS) rdata = masked;
    end
  end
endmodule

// File: rtl/irq_combiner_chk.sv
module irq_combiner_chk #(
  parameter int NGRP = 4,
  parameter int AW   = 8,
  localparam int NSRC = NGRP * 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_i,
  input logic            wr_en,
  input logic            rd_en,
  input logic [AW-1:0]   addr,
  input logic [NSRC-1:0] wdata,
  input logic [NSRC-1:0] rdata,
  input logic [NGRP-1:0] grp_irq,
  input logic [NSRC-1:0] en_q
);
  a_r1_reset_clear: assert property (@(posedge clk) $rose(rst_n) |-> (en_q == '0 && grp_irq == '0));

  a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(8'h00)) |=> ((en_q & $past(wdata)) == $past(wdata)));

  a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(8'h04)) |=> ((en_q & $past(wdata)) == '0));

  a_r4_status_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(8'h0C)) |-> ((rdata & ~en_q) == '0));

  a_r5_no_req_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_q) == '0) |-> (grp_irq == '0));

  a_r6_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(8'h04)) |-> (rdata == '0));

  a_r7_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != AW'(8'h00) && addr != AW'(8'h04)) |=> $stable(en_q));
endmodule

bind irq_combiner irq_combiner_chk #(.NGRP(NGRP), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .rdata(rdata), .grp_irq(grp_irq), .en_q(en_q)
);

// File: tb/irq_combiner_bench.sv
module irq_combiner_bench;
  localparam int NGRP = 4;
  localparam int AW   = 8;
  localparam int NSRC = 32;

  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] src_i = '0, wdata = '0;
  logic wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [NSRC-1:0] rdata;
  logic [NGRP-1:0] grp_irq;

  int checks = 0, errors = 0;
  logic [NSRC-1:0] ref_en = '0;
  logic done = 0;

  always #2 clk = ~clk;

  irq_combiner #(.NGRP(NGRP), .AW(AW)) u_irq_combiner (.*);

  function automatic logic [NGRP-1:0] exp_grp(input logic [NSRC-1:0] s, input logic [NSRC-1:0] e);
    logic [NGRP-1:0] r;
    for (int g = 0; g < NGRP; g++) r[g] = |(s[8*g +: 8] & e[8*g +: 8]);
    return r;
  endfunction

  task automatic chk(input string req, input logic [NSRC-1:0] act, input logic [NSRC-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NSRC-1:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    if (a == 8'h00) ref_en = ref_en | d;
    else if (a == 8'h04) ref_en = ref_en & ~d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [NSRC-1:0] d);
    @(negedge clk);
    rd_en = 1; addr = a;
    #1 d = rdata;
    rd_en = 0;
  endtask

  task automatic check_all(input string tag);
    logic [NSRC-1:0] d;
    rd(8'h00, d); chk({tag, " R6 enable readback"}, d, ref_en);
    rd(8'h0C, d); chk({tag, " R4 status"}, d, src_i & ref_en);
    @(negedge clk);
    chk({tag, " R5 group outputs"}, NSRC'(grp_irq), NSRC'(exp_grp(src_i, ref_en)));
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NSRC-1:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    src_i = '1;
    rst_n = 1;
    @(negedge clk);
    rd(8'h0C, d); chk("R1 status after reset", d, '0);
    rd(8'h00, d); chk("R1 enables after reset", d, '0);
    chk("R1 groups after reset", NSRC'(grp_irq), '0);

    wr(8'h00, 32'h0000_0081); check_all("R2 set lane0");
    wr(8'h00, 32'h0100_0000); check_all("R2 set lane3");
    wr(8'h04, 32'h0000_0001); check_all("R3 clear one");
    rd(8'h04, d); chk("R6 clear reads zero", d, '0);

    src_i = 32'h0000_0001;
    @(negedge clk);
    chk("R5 disabled source quiet", NSRC'(grp_irq), '0);
    src_i = 32'h0000_0080;
    @(negedge clk);
    chk("R5 lane0 request", NSRC'(grp_irq), 32'h1);
    src_i = 32'h0100_0000;
    @(negedge clk);
    chk("R5 lane3 only", NSRC'(grp_irq), 32'h8);

    wr(8'h08, '1); check_all("R7 write 0x08");
    wr(8'h0C, '1); check_all("R7 write 0x0C");
    wr(8'h10, '1); check_all("R7 write 0x10");
    rd(8'h08, d); chk("R7 read 0x08", d, '0);
    rd(8'h40, d); chk("R7 read 0x40", d, '0);

    wr(8'h00, '1);
    src_i = 32'h00FF_0000; check_all("R5 full enable lane2");
    wr(8'h04, '1); check_all("R3 clear all");

    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] a;
      case ($urandom_range(0, 3))
        0: a = 8'h00;
        1: a = 8'h04;
        2: a = 8'h08;
        default: a = 8'h0C;
      endcase
      src_i = $urandom();
      wr(a, $urandom() & $urandom());
      check_all("random R2 R3");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule